// File: doc/BRIEF.md
# Edge-Selectable Interrupt Control Register

This block is the per-source control and status byte of an interrupt controller. It holds a three-bit priority level and a request flag. When the source is an external pin, it also holds a bit that picks which edge is detected. The block watches its interrupt input and latches a request when the chosen event occurs. Software can read the byte and can clear the request, but it can never set the request. The block drives a pending line and the current level toward an arbiter outside the block. When that arbiter takes the interrupt, it clears the request through an acknowledge input.

A parameter picks one of two variants. In the external variant, the input is an asynchronous pin. It passes through a synchronizer, and its edge is detected according to the polarity bit. In the internal variant, the input is a synchronous pulse from a peripheral, and the request is latched on every clock where that pulse is high. A level of zero masks the source toward the arbiter, but the request flag still latches.

Top module: `irqctl_top`

## Requirements
- R1: After reset, the read value is 0x00, `pending` is 0 and `level` is 0.
- R2: A write loads bits 2..0 of the write data into the priority level. The level appears on `level` and on read bits 2..0 after the next clock edge.
- R3: Read bit 3 is the request flag. A write with bit 3 = 0 clears the flag. A write with bit 3 = 1 leaves the flag unchanged.
- R4: In the external variant, read bit 4 is the polarity bit and is writable, while bits 7..5 always read 0. In the internal variant, bits 7..3 read 0 apart from the flag at bit 3. In both variants, writes to the unassigned bits have no effect.
- R5: External variant with polarity 1: a rising edge on `irqIn` sets the flag. The flag reads 1 three clock edges after the input changes, and still reads 0 after two.
- R6: External variant with polarity 0: a falling edge on `irqIn` sets the flag, with the same latency as R5.
- R7: `pending` is 1 exactly when the flag is 1 and the level is nonzero. At level 0 the flag still latches, but `pending` stays 0.
- R8: When a hardware set coincides with a clearing write or with an acknowledge, the flag ends up 1.
- R9: A one-cycle pulse on `ack` clears the flag.
- R10: A write that changes the polarity bit while the input is steady never sets the flag, for either input level and either switching direction.
- R11: Internal variant: a cycle with `irqIn` high sets the flag at that clock edge, with no synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 1 | Interrupt source: a pin in the external variant, a pulse in the internal variant |
| wrEn | input | 1 | Write strobe for the control byte |
| wrData | input | 8 | Write data |
| ack | input | 1 | Arbiter acknowledge; clears the request |
| rdData | output | 8 | Current control byte |
| pending | output | 1 | Request flag set and level nonzero |
| level | output | 3 | Current priority level |

## Verification
The hardest case to reach is R8, where a hardware set and a clear land on the same clock edge. The bench raises the pin and counts the two synchronizer edges. It then drives a clearing write and an acknowledge together, so that both hit the edge on which the edge detector fires. The polarity-switch case (R10) is reached by holding the pin steady at each level in turn and flipping the polarity in both directions. This shows that a reloaded history does not produce a request. A sweep over all 256 write values covers the bit layout in both variants.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;
  localparam int DATA_W  = 8;
  localparam int LEVEL_W = 3;
  localparam int FLAG_BIT = 3;   // neighbour software decodes this position
  localparam int POL_BIT  = 4;

  typedef struct packed {
    logic setFlag;     // hardware event detected
    logic clrFlag;     // software clear or acknowledge
    logic loadCfg;     // level and polarity load
    logic reloadHist;  // polarity changes: refresh edge history
  } irqStrobes_t;
endpackage

// File: rtl/irqctl_datapath.sv
module irqctl_datapath
  import irqctl_pkg::*;
#(
  parameter bit IS_EXTERNAL = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqIn,
  input  logic [DATA_W-1:0] wrData,
  input  irqStrobes_t       strb,
  output logic              edgeSeen,
  output logic              polReg,
  output logic              flagReg,
  output logic [LEVEL_W-1:0] levelReg,
  output logic [DATA_W-1:0] rdData,
  output logic              pending
);

  generate
    if (IS_EXTERNAL) begin : g_ext
      logic [SYNC_STAGES-1:0] syncQ;
      logic normNow;
      logic prevNorm;
      logic polQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], irqIn};
      end

      // active edge always becomes a rising edge of normNow
      assign normNow  = syncQ[SYNC_STAGES-1] ^ ~polQ;
      assign edgeSeen = normNow & ~prevNorm;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                prevNorm <= 1'b1;
        else if (strb.reloadHist) prevNorm <= syncQ[SYNC_STAGES-1] ^ ~wrData[POL_BIT];
        else                      prevNorm <= normNow;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             polQ <= 1'b0;
        else if (strb.loadCfg) polQ <= wrData[POL_BIT];
      end
      assign polReg = polQ;
    end else begin : g_int
      assign edgeSeen = irqIn;
      assign polReg   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             flagReg <= 1'b0;
    else if (strb.setFlag) flagReg <= 1'b1;
    else if (strb.clrFlag) flagReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             levelReg <= '0;
    else if (strb.loadCfg) levelReg <= wrData[LEVEL_W-1:0];
  end

  always_comb begin
    rdData                   = '0;
    rdData[LEVEL_W-1:0]      = levelReg;
    rdData[FLAG_BIT]         = flagReg;
    rdData[POL_BIT]          = polReg;
  end

  assign pending = flagReg & (|levelReg);

endmodule

// File: rtl/irqctl_control.sv
module irqctl_control
  import irqctl_pkg::*;
#(
  parameter bit IS_EXTERNAL = 1'b1
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ack,
  input  logic              edgeSeen,
  input  logic              polReg,
  output irqStrobes_t       strb
);

  always_comb begin
    strb.setFlag    = edgeSeen;
    strb.clrFlag    = (wrEn & ~wrData[FLAG_BIT]) | ack;
    strb.loadCfg    = wrEn;
    strb.reloadHist = IS_EXTERNAL & wrEn & (wrData[POL_BIT] != polReg);
  end

endmodule

// File: rtl/irqctl_top.sv
module irqctl_top
  import irqctl_pkg::*;
#(
  parameter bit IS_EXTERNAL = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               irqIn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               ack,
  output logic [DATA_W-1:0]  rdData,
  output logic               pending,
  output logic [LEVEL_W-1:0] level
);

  irqStrobes_t ctlStrobes;
  logic edgeSeen;
  logic polReg;
  logic flagReg;

  irqctl_control #(.IS_EXTERNAL(IS_EXTERNAL)) u_control (
    .wrEn     (wrEn),
    .wrData   (wrData),
    .ack      (ack),
    .edgeSeen (edgeSeen),
    .polReg   (polReg),
    .strb     (ctlStrobes)
  );

  irqctl_datapath #(.IS_EXTERNAL(IS_EXTERNAL), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .wrData   (wrData),
    .strb     (ctlStrobes),
    .edgeSeen (edgeSeen),
    .polReg   (polReg),
    .flagReg  (flagReg),
    .levelReg (level),
    .rdData   (rdData),
    .pending  (pending)
  );

endmodule

// File: rtl/irqctl_checker.sv
module irqctl_checker
  import irqctl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic               ack,
  input logic [DATA_W-1:0]  rdData,
  input logic               pending,
  input logic [LEVEL_W-1:0] level,
  input logic               setFlag
);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    setFlag |=> rdData[FLAG_BIT]); // R8

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[FLAG_BIT] && !setFlag) |=> !rdData[FLAG_BIT]); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !setFlag) |=> !rdData[FLAG_BIT]); // R9

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (level == $past(wrData[LEVEL_W-1:0]))); // R2

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !pending); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:POL_BIT+1] == '0); // R4

endmodule

bind irqctl_top irqctl_checker u_irqctl_checker (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .ack     (ack),
  .rdData  (rdData),
  .pending (pending),
  .level   (level),
  .setFlag (ctlStrobes.setFlag)
);

// File: tb/irqctl_top_bench.sv
`timescale 1ns/1ps
module irqctl_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic irqE = 0, wrEnE = 0, ackE = 0;
  logic [7:0] wrDataE = 0, rdE;
  logic pendE;
  logic [2:0] lvlE;
  logic irqI = 0, wrEnI = 0, ackI = 0;
  logic [7:0] wrDataI = 0, rdI;
  logic pendI;
  logic [2:0] lvlI;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irqctl_top #(.IS_EXTERNAL(1'b1)) u_irqctl_top (
    .clk(clk), .rstN(rstN), .irqIn(irqE), .wrEn(wrEnE), .wrData(wrDataE),
    .ack(ackE), .rdData(rdE), .pending(pendE), .level(lvlE));

  irqctl_top #(.IS_EXTERNAL(1'b0)) u_irqctl_top_int (
    .clk(clk), .rstN(rstN), .irqIn(irqI), .wrEn(wrEnI), .wrData(wrDataI),
    .ack(ackI), .rdData(rdI), .pending(pendI), .level(lvlI));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrExt(input logic [7:0] d);
    @(negedge clk); wrEnE = 1; wrDataE = d;
    @(negedge clk); wrEnE = 0;
  endtask

  task automatic wrInt(input logic [7:0] d);
    @(negedge clk); wrEnI = 1; wrDataI = d;
    @(negedge clk); wrEnI = 0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    waitN(3);
    chk("R1 ext rd", rdE, 0);   chk("R1 ext pending", pendE, 0); chk("R1 ext level", lvlE, 0);
    chk("R1 int rd", rdI, 0);   chk("R1 int pending", pendI, 0); chk("R1 int level", lvlI, 0);
    rstN = 1;
    waitN(4);
    chk("R1 ext rd after release", rdE, 0);

    // R2 R3 R4: full write sweep, no input activity
    for (int d = 0; d < 256; d++) begin
      wrExt(8'(d));
      chk("R4 ext layout", rdE, d & 8'h17);
      chk("R2 ext level", lvlE, d & 7);
      chk("R3 ext no sw set", pendE, 0);
      wrInt(8'(d));
      chk("R4 int layout", rdI, d & 8'h07);
      chk("R2 int level", lvlI, d & 7);
    end

    // R5 rising edge with latency
    wrExt(8'h15);
    @(negedge clk); irqE = 1;
    waitN(2);
    chk("R5 not yet", rdE[3], 0);
    waitN(1);
    chk("R5 rise latched", rdE[3], 1);
    chk("R7 pending lvl5", pendE, 1);

    // R3 write 1 keeps, write 0 clears
    wrExt(8'h1D);
    chk("R3 write1 keeps", rdE[3], 1);
    wrExt(8'h15);
    chk("R3 write0 clears", rdE[3], 0);

    // R6 falling edge
    wrExt(8'h05);
    waitN(4);
    chk("R6 no event yet", rdE[3], 0);
    @(negedge clk); irqE = 0;
    waitN(2);
    chk("R6 not yet", rdE[3], 0);
    waitN(1);
    chk("R6 fall latched", rdE[3], 1);

    // R7 pending across all levels, flag kept by writing 1
    for (int l = 0; l < 8; l++) begin
      wrExt(8'h08 | 8'(l));
      chk("R7 flag kept", rdE[3], 1);
      chk("R7 pending vs level", pendE, (l != 0) ? 1 : 0);
    end
    wrExt(8'h00);
    @(negedge clk); irqE = 1;
    waitN(4);
    @(negedge clk); irqE = 0;
    waitN(4);
    chk("R7 level0 latches", rdE[3], 1);
    chk("R7 level0 masked", pendE, 0);

    // R9 acknowledge
    wrExt(8'h0A);
    chk("R9 pending before ack", pendE, 1);
    @(negedge clk); ackE = 1;
    @(negedge clk); ackE = 0;
    chk("R9 ack clears", rdE[3], 0);
    chk("R9 pending gone", pendE, 0);

    // R8 set wins against clearing write plus ack
    wrExt(8'h13);
    @(negedge clk); irqE = 1;
    waitN(2);
    wrEnE = 1; wrDataE = 8'h13; ackE = 1;
    @(negedge clk); wrEnE = 0; ackE = 0;
    chk("R8 set beats clear", rdE[3], 1);

    // R10 polarity switches, input high then low
    wrExt(8'h13);
    chk("R10 cleared", rdE[3], 0);
    wrExt(8'h03);
    wrExt(8'h13);
    waitN(4);
    chk("R10 high input switches", rdE[3], 0);
    @(negedge clk); irqE = 0;
    waitN(4);
    chk("R10 falling ignored pol1", rdE[3], 0);
    wrExt(8'h03);
    waitN(3);
    chk("R10 low input to pol0", rdE[3], 0);
    wrExt(8'h13);
    waitN(3);
    chk("R10 low input to pol1", rdE[3], 0);

    // R11 internal pulse
    wrInt(8'h04);
    @(negedge clk); irqI = 1;
    @(negedge clk); irqI = 0;
    chk("R11 pulse latched", rdI[3], 1);
    chk("R11 pending", pendI, 1);
    wrInt(8'h0C);
    chk("R3 int write1 keeps", rdI[3], 1);
    @(negedge clk); ackI = 1;
    @(negedge clk); ackI = 0;
    chk("R9 int ack clears", rdI[3], 0);
    @(negedge clk); irqI = 1; wrEnI = 1; wrDataI = 8'h04;
    @(negedge clk); irqI = 0; wrEnI = 0;
    chk("R8 int set beats write", rdI[3], 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule